// File: doc/BRIEF.md
# TDC Hit Word Builder

This block turns the raw edge records of a bank of TDC channels into hit words for the readout FIFO. It runs once for each second-level accept. A single-cycle `start_i` captures the accept context and the channel skip mask. The block then walks the channels in ascending order and reads every enabled channel until that channel returns an empty record. Skipped channels are never touched. Leading and trailing edges are paired into a pulse width and a hit time. An edge with no partner still produces a hit word, with a fixed sentinel width.

Hit words are held in an internal staging buffer until every channel has been read. After that the block writes one header word into the output FIFO, followed by all staged hits. The header carries the number of hits, the scan list, the L2 buffer address, a module ID and the buffered crossing count after the trigger decision latency has been subtracted. The FIFO write port honours a full flag: while it is high, no word is written and no word is lost.

Top module: `tdc_hit_builder`

## Requirements
- R1: An edge record is decoded as follows: bit 31 = 1 means the channel has no more edges, bit 11 = 1 means a rising (leading) edge and 0 a falling (trailing) edge, and bits 10:0 give the edge time. Each enabled channel is read one record per cycle until a record with bit 31 set is returned.
- R2: A hit word holds the first-hit flag in bit 31, the channel number in 30:22, the pulse width in 21:11 and the hit time in 10:0. A leading edge followed by a trailing edge gives time = leading time and width = (trailing − leading) mod 2048.
- R3: A leading edge with no trailing partner gives width 0x7FF and time = its own time. This applies when another leading edge follows it and when the channel ends.
- R4: A trailing edge with no pending leading edge gives width 0 and time = its own time.
- R5: The first-hit flag is 1 on the first hit word of each channel within an event and 0 on that channel's later hit words.
- R6: A channel whose skip-mask bit is 1 is not read. Its edge records stay in its buffer for a later event.
- R7: Hit words appear channel by channel in ascending channel order, and in edge order within a channel.
- R8: Each event writes exactly one header word and then all of its hits. The header holds the module ID in 31:23, the scan list in 22:20, the L2 buffer address in 19:18, the hit count in 17:8 and the corrected crossing count in 7:0.
- R9: The corrected crossing count is raw − 42 when raw ≥ 42, and raw + 117 (that is, modulo 159) when raw < 42, for raw counts 0 to 158.
- R10: No word is written while `fifo_full_i` is 1. Output resumes in order, with no loss, once the flag drops.
- R11: At most STAGE_DEPTH hits are kept per event. Later hits are discarded, and the header count equals the number of hits actually written.
- R12: After reset the block is idle: `busy_o`, `done_o`, `edge_rd_o` and `fifo_wr_o` are all 0. `done_o` pulses for one cycle after the last word of an event has been written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Accept strobe; starts an event when idle |
| skip_mask_i | input | NUM_CH | 1 = channel skipped (dead) |
| module_id_i | input | 9 | Module ID placed in the header |
| scan_list_i | input | 3 | Scan list placed in the header |
| l2ba_i | input | 2 | L2 buffer address placed in the header |
| bcc_raw_i | input | 8 | Buffered crossing count, 0 to 158 |
| edge_rd_o | output | 1 | Pops one record from the selected channel |
| edge_ch_o | output | 9 | Channel being read |
| edge_word_i | input | 32 | Head record of the selected channel |
| fifo_wr_o | output | 1 | Output FIFO write strobe |
| fifo_data_o | output | 32 | Header or hit word |
| fifo_full_i | input | 1 | Output FIFO full |
| busy_o | output | 1 | Event in progress |
| done_o | output | 1 | One-cycle pulse at event end |

## Verification
The bench targets the following corner cases of the pairing logic, each with the failure it would expose:
- Leading edge followed by another leading edge: a design that overwrites the pending edge loses a hit.
- Trailing edge with nothing pending: a design that pairs it against a stale time produces a bogus width.
- Width that wraps below zero: a design that saturates the subtraction reports the wrong width.

For the crossing correction, the bench checks raw counts 0, 41, 42 and 158. This catches a modulo-256 wrap, or an off-by-one at the latency boundary.

The bench also covers four ordering and flow cases:
- A full FIFO held high: a design that ignores it writes words.
- A skipped channel that is read anyway: its edges are consumed, so the next event returns no hits for it.
- Staging overflow: a design that counts discarded hits writes a header whose count disagrees with the words that follow.
- Header placement: the header must come before the hits, not after them.

// File: rtl/tdc_hb_pkg.sv
package tdc_hb_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned TIME_W   = 11;
  localparam int unsigned CHF_W    = 9;
  localparam int unsigned CNTF_W   = 10;
  localparam int unsigned BCC_W    = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_HDR,
    ST_DRAIN
  } hb_state_e;

  function automatic logic [WORD_W-1:0] pack_hit(
    input logic              first,
    input logic [CHF_W-1:0]  ch,
    input logic [TIME_W-1:0] width,
    input logic [TIME_W-1:0] t
  );
    return {first, ch, width, t};
  endfunction

  function automatic logic [WORD_W-1:0] pack_hdr(
    input logic [8:0]        mid,
    input logic [2:0]        sl,
    input logic [1:0]        ba,
    input logic [CNTF_W-1:0] n,
    input logic [BCC_W-1:0]  bcc
  );
    return {mid, sl, ba, n, bcc};
  endfunction
endpackage

// File: rtl/tdc_edge_pairer.sv
module tdc_edge_pairer
  import tdc_hb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [CHF_W-1:0]  ch_i,
  output logic              emit_o,
  output logic [WORD_W-1:0] hit_o
);
  localparam logic [TIME_W-1:0] W_OPEN  = '1;
  localparam logic [TIME_W-1:0] W_ORPH  = '0;

  logic              pend_q, pend_d;
  logic              seen_q;
  logic [TIME_W-1:0] lead_q, lead_d;
  logic [TIME_W-1:0] t_in;
  logic              is_empty, is_rise;

  assign t_in     = word_i[TIME_W-1:0];
  assign is_empty = word_i[31];
  assign is_rise  = word_i[11];

  always_comb begin
    emit_o = 1'b0;
    hit_o  = '0;
    pend_d = pend_q;
    lead_d = lead_q;
    if (valid_i) begin
      if (is_empty) begin
        if (pend_q) begin
          emit_o = 1'b1;
          hit_o  = pack_hit(!seen_q, ch_i, W_OPEN, lead_q);
        end
        pend_d = 1'b0;
      end else if (is_rise) begin
        if (pend_q) begin
          emit_o = 1'b1;
          hit_o  = pack_hit(!seen_q, ch_i, W_OPEN, lead_q);
        end
        pend_d = 1'b1;
        lead_d = t_in;
      end else begin
        emit_o = 1'b1;
        if (pend_q) hit_o = pack_hit(!seen_q, ch_i, t_in - lead_q, lead_q);
        else        hit_o = pack_hit(!seen_q, ch_i, W_ORPH, t_in);
        pend_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      seen_q <= 1'b0;
      lead_q <= '0;
    end else if (clear_i) begin
      pend_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      lead_q <= lead_d;
      if (emit_o) seen_q <= 1'b1;
    end
  end
endmodule

// File: rtl/tdc_stage_buf.sv
module tdc_stage_buf
  import tdc_hb_pkg::*;
#(
  parameter int unsigned DEPTH = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [$clog2(DEPTH+1)-1:0] raddr_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic              full_o
);
  localparam int unsigned CW = $clog2(DEPTH+1);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [CW-1:0]     cnt_q;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign count_o = cnt_q;
  assign rdata_o = mem_q[AW'(raddr_i)];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (wr_i && !full_o)   cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_i && !full_o) mem_q[AW'(cnt_q)] <= wdata_i;
  end
endmodule

// File: rtl/tdc_bcc_fix.sv
module tdc_bcc_fix
  import tdc_hb_pkg::*;
#(
  parameter int unsigned LATENCY = 42,
  parameter int unsigned PERIOD  = 159
) (
  input  logic [BCC_W-1:0] raw_i,
  output logic [BCC_W-1:0] fixed_o
);
  localparam logic [BCC_W-1:0] LAT_V  = BCC_W'(LATENCY);
  localparam logic [BCC_W-1:0] WRAP_V = BCC_W'(PERIOD - LATENCY);

  always_comb begin
    if (raw_i >= LAT_V) fixed_o = raw_i - LAT_V;
    else                fixed_o = raw_i + WRAP_V;
  end
endmodule

// File: rtl/tdc_hit_builder.sv
module tdc_hit_builder
  import tdc_hb_pkg::*;
#(
  parameter int unsigned NUM_CH      = 96,
  parameter int unsigned STAGE_DEPTH = 512,
  parameter int unsigned LATENCY     = 42,
  parameter int unsigned BCC_PERIOD  = 159
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [NUM_CH-1:0] skip_mask_i,
  input  logic [8:0]        module_id_i,
  input  logic [2:0]        scan_list_i,
  input  logic [1:0]        l2ba_i,
  input  logic [7:0]        bcc_raw_i,
  output logic              edge_rd_o,
  output logic [8:0]        edge_ch_o,
  input  logic [31:0]       edge_word_i,
  output logic              fifo_wr_o,
  output logic [31:0]       fifo_data_o,
  input  logic              fifo_full_i,
  output logic              busy_o,
  output logic              done_o
);
  localparam int unsigned CCW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int unsigned SCW = $clog2(STAGE_DEPTH+1);
  localparam logic [CCW-1:0] LAST_CH = CCW'(NUM_CH-1);

  hb_state_e         state_q;
  logic [CCW-1:0]    ch_q;
  logic [NUM_CH-1:0] skip_q;
  logic [8:0]        mid_q;
  logic [2:0]        sl_q;
  logic [1:0]        ba_q;
  logic [7:0]        bcc_q;
  logic [SCW-1:0]    rptr_q;
  logic              done_q;

  logic              accept;
  logic              cur_skip;
  logic              chan_end;
  logic              emit;
  logic [WORD_W-1:0] hit;
  logic [WORD_W-1:0] stage_rdata;
  logic [SCW-1:0]    stage_cnt;
  logic              stage_full;
  logic [7:0]        bcc_fixed;
  logic              out_go;
  logic              last_word;

  assign accept   = start_i && (state_q == ST_IDLE);
  assign cur_skip = skip_q[ch_q];
  assign edge_rd_o = (state_q == ST_SCAN) && !cur_skip;
  assign edge_ch_o = 9'(ch_q);
  assign chan_end = (state_q == ST_SCAN) && (cur_skip || edge_word_i[31]);

  tdc_edge_pairer u_pair (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (accept || chan_end),
    .valid_i (edge_rd_o),
    .word_i  (edge_word_i),
    .ch_i    (edge_ch_o),
    .emit_o  (emit),
    .hit_o   (hit)
  );

  tdc_stage_buf #(.DEPTH(STAGE_DEPTH)) u_stage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (accept),
    .wr_i    (emit),
    .wdata_i (hit),
    .raddr_i (rptr_q),
    .rdata_o (stage_rdata),
    .count_o (stage_cnt),
    .full_o  (stage_full)
  );

  tdc_bcc_fix #(.LATENCY(LATENCY), .PERIOD(BCC_PERIOD)) u_bcc (
    .raw_i   (bcc_q),
    .fixed_o (bcc_fixed)
  );

  assign out_go    = ((state_q == ST_HDR) || (state_q == ST_DRAIN)) && !fifo_full_i;
  assign fifo_wr_o = out_go;
  assign last_word = (rptr_q == stage_cnt - 1'b1);

  always_comb begin
    if (state_q == ST_HDR)
      fifo_data_o = pack_hdr(mid_q, sl_q, ba_q, CNTF_W'(stage_cnt), bcc_fixed);
    else if (state_q == ST_DRAIN)
      fifo_data_o = stage_rdata;
    else
      fifo_data_o = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
      skip_q  <= '0;
      mid_q   <= '0;
      sl_q    <= '0;
      ba_q    <= '0;
      bcc_q   <= '0;
      rptr_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          skip_q  <= skip_mask_i;
          mid_q   <= module_id_i;
          sl_q    <= scan_list_i;
          ba_q    <= l2ba_i;
          bcc_q   <= bcc_raw_i;
          ch_q    <= '0;
          state_q <= ST_SCAN;
        end
        ST_SCAN: if (chan_end) begin
          if (ch_q == LAST_CH) state_q <= ST_HDR;
          else                 ch_q    <= ch_q + 1'b1;
        end
        ST_HDR: if (out_go) begin
          rptr_q <= '0;
          if (stage_cnt == '0) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= ST_DRAIN;
          end
        end
        ST_DRAIN: if (out_go) begin
          if (last_word) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            rptr_q <= rptr_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
endmodule

// File: rtl/tdc_hit_builder_chk.sv
module tdc_hit_builder_chk #(
  parameter int unsigned NUM_CH      = 96,
  parameter int unsigned STAGE_DEPTH = 512
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              edge_rd_o,
  input logic [8:0]        edge_ch_o,
  input logic              fifo_wr_o,
  input logic              fifo_full_i,
  input logic [NUM_CH-1:0] skip_q,
  input logic [$clog2(STAGE_DEPTH+1)-1:0] stage_cnt
);
  localparam int unsigned SCW = $clog2(STAGE_DEPTH+1);

  logic [SCW:0] wr_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 wr_n <= '0;
    else if (start_i && !busy_o) wr_n <= '0;
    else if (fifo_wr_o)          wr_n <= wr_n + 1'b1;
  end

  p_no_wr_full_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_o |-> !fifo_full_i);

  p_skip_unread_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_rd_o |-> (edge_ch_o < 9'(NUM_CH)) && !skip_q[edge_ch_o]);

  p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !edge_rd_o && !fifo_wr_o);

  p_count_match_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (wr_n == (SCW+1)'(stage_cnt) + 1'b1));

  p_stage_bound_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_cnt <= SCW'(STAGE_DEPTH));

  p_ch_ascend_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_rd_o && $past(edge_rd_o)) |-> (edge_ch_o >= $past(edge_ch_o)));

  p_done_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind tdc_hit_builder tdc_hit_builder_chk #(
  .NUM_CH(NUM_CH),
  .STAGE_DEPTH(STAGE_DEPTH)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .edge_rd_o   (edge_rd_o),
  .edge_ch_o   (edge_ch_o),
  .fifo_wr_o   (fifo_wr_o),
  .fifo_full_i (fifo_full_i),
  .skip_q      (skip_q),
  .stage_cnt   (stage_cnt)
);

// File: tb/tdc_hit_builder_test.sv
module tdc_hit_builder_test;
  localparam int NCH = 8;
  localparam int SD  = 8;
  localparam int QD  = 8;
  localparam logic [31:0] EMPTY_W = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [NCH-1:0] skip = '1;
  logic [8:0]  mid = 9'h1A5;
  logic [2:0]  sl = 3'd5;
  logic [1:0]  ba = 2'd2;
  logic [7:0]  bcc = 8'd100;
  logic        rd;
  logic [8:0]  ch;
  logic [31:0] eword;
  logic        wr;
  logic [31:0] wdata;
  logic        full = 1'b0;
  logic        busy, done;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  tdc_hit_builder #(.NUM_CH(NCH), .STAGE_DEPTH(SD)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .skip_mask_i(skip),
    .module_id_i(mid), .scan_list_i(sl), .l2ba_i(ba), .bcc_raw_i(bcc),
    .edge_rd_o(rd), .edge_ch_o(ch), .edge_word_i(eword),
    .fifo_wr_o(wr), .fifo_data_o(wdata), .fifo_full_i(full),
    .busy_o(busy), .done_o(done)
  );

  // per-channel edge source model
  logic [31:0] qm [NCH][QD];
  int qh [NCH];
  int qn [NCH];

  always_comb begin
    eword = EMPTY_W;
    if (int'(ch) < NCH && qh[int'(ch)] < qn[int'(ch)]) eword = qm[int'(ch)][qh[int'(ch)]];
  end

  always @(posedge clk)
    if (rd && int'(ch) < NCH && qh[int'(ch)] < qn[int'(ch)]) qh[int'(ch)] <= qh[int'(ch)] + 1;

  logic [31:0] cap [64];
  int ncap = 0;
  always @(posedge clk)
    if (wr) begin
      if (ncap < 64) cap[ncap] <= wdata;
      ncap <= ncap + 1;
    end

  function automatic logic [31:0] rise(int t);
    return {1'b0, 19'h7FFFF, 1'b1, 11'(t)};
  endfunction
  function automatic logic [31:0] fall(int t);
    return {1'b0, 19'h7FFFF, 1'b0, 11'(t)};
  endfunction
  function automatic logic [31:0] mk_hit(int f, int c, int w, int t);
    return {1'(f), 9'(c), 11'(w), 11'(t)};
  endfunction
  function automatic logic [31:0] mk_hdr(int n, int b);
    return {9'h1A5, 3'd5, 2'd2, 10'(n), 8'(b)};
  endfunction

  // columns: edge0, edge1, edge2 (0 = none), hit count, hit0, hit1 ; channel 2 only
  localparam logic [31:0] TV [7][6] = '{
    '{rise(100), fall(150), 32'h0, 32'd1, mk_hit(1,2,50,100), 32'h0},
    '{rise(10), 32'h0, 32'h0, 32'd1, mk_hit(1,2,2047,10), 32'h0},
    '{fall(20), 32'h0, 32'h0, 32'd1, mk_hit(1,2,0,20), 32'h0},
    '{rise(5), rise(30), fall(40), 32'd2, mk_hit(1,2,2047,5), mk_hit(0,2,10,30)},
    '{fall(3), rise(8), fall(9), 32'd2, mk_hit(1,2,0,3), mk_hit(0,2,1,8)},
    '{32'h0, 32'h0, 32'h0, 32'd0, 32'h0, 32'h0},
    '{rise(2000), fall(30), 32'h0, 32'd1, mk_hit(1,2,78,2000), 32'h0}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic clr_q();
    for (int c = 0; c < NCH; c++) begin
      qh[c] = 0;
      qn[c] = 0;
    end
  endtask

  task automatic push(int c, logic [31:0] w);
    qm[c][qn[c]] = w;
    qn[c] = qn[c] + 1;
  endtask

  task automatic run_event(logic [NCH-1:0] m, logic [7:0] b);
    @(negedge clk);
    skip = m;
    bcc = b;
    ncap = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int cyc = 0;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL R12: done never seen, got 0 expected 1");
    end
    @(negedge clk);
  endtask

  initial begin
    #1_900_000;
    n_fail++;
    $display("FAIL R12: watchdog expired, got hang expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    clr_q();
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 busy", 32'(busy), 0);
    chk("R12 done", 32'(done), 0);
    chk("R12 rd", 32'(rd), 0);
    chk("R12 wr", 32'(wr), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: channel 2 only, R1..R5, R8
    for (int i = 0; i < 7; i++) begin
      clr_q();
      for (int k = 0; k < 3; k++) if (TV[i][k] != 0) push(2, TV[i][k]);
      run_event(~8'b0000_0100, 8'd100);
      wait_done();
      chk("R8 words", 32'(ncap), TV[i][3] + 1);
      chk("R8 header", cap[0], mk_hdr(int'(TV[i][3]), 58));
      if (TV[i][3] >= 1) chk("R2 R3 R4 hit0", cap[1], TV[i][4]);
      if (TV[i][3] >= 2) chk("R5 hit1", cap[2], TV[i][5]);
      chk("R1 drained", 32'(qh[2]), 32'(qn[2]));
    end

    // R7 / R5 multiple channels
    clr_q();
    push(0, rise(1)); push(0, fall(4));
    push(3, fall(7));
    push(5, rise(2)); push(5, fall(12)); push(5, rise(20));
    run_event('0, 8'd100);
    wait_done();
    chk("R7 words", 32'(ncap), 5);
    chk("R7 header", cap[0], mk_hdr(4, 58));
    chk("R7 h0", cap[1], mk_hit(1,0,3,1));
    chk("R7 h1", cap[2], mk_hit(1,3,0,7));
    chk("R5 h2", cap[3], mk_hit(1,5,10,2));
    chk("R3 h3", cap[4], mk_hit(0,5,2047,20));

    // R6 skipped channel keeps its edges
    clr_q();
    push(1, rise(50)); push(1, fall(60));
    push(2, fall(9));
    run_event(~8'b0000_0100, 8'd100);
    wait_done();
    chk("R6 words", 32'(ncap), 2);
    chk("R6 hit", cap[1], mk_hit(1,2,0,9));
    run_event(~8'b0000_0010, 8'd100);
    wait_done();
    chk("R6 later words", 32'(ncap), 2);
    chk("R6 later hit", cap[1], mk_hit(1,1,10,50));

    // R9 crossing correction
    clr_q();
    run_event('1, 8'd0);   wait_done(); chk("R9 raw0", cap[0], mk_hdr(0,117));
    run_event('1, 8'd41);  wait_done(); chk("R9 raw41", cap[0], mk_hdr(0,158));
    run_event('1, 8'd42);  wait_done(); chk("R9 raw42", cap[0], mk_hdr(0,0));
    run_event('1, 8'd158); wait_done(); chk("R9 raw158", cap[0], mk_hdr(0,116));

    // R10 full stall
    clr_q();
    push(2, rise(100)); push(2, fall(150));
    @(negedge clk);
    full = 1'b1;
    run_event(~8'b0000_0100, 8'd100);
    repeat (40) @(negedge clk);
    chk("R10 no write", 32'(ncap), 0);
    chk("R10 busy", 32'(busy), 1);
    full = 1'b0;
    wait_done();
    chk("R10 words", 32'(ncap), 2);
    chk("R10 header", cap[0], mk_hdr(1,58));
    chk("R10 hit", cap[1], mk_hit(1,2,50,100));

    // R11 staging overflow
    clr_q();
    for (int k = 0; k < 8; k++) push(0, fall(k));
    for (int k = 0; k < 3; k++) push(1, fall(100 + k));
    run_event('0, 8'd100);
    wait_done();
    chk("R11 words", 32'(ncap), 9);
    chk("R11 header", cap[0], mk_hdr(8,58));
    chk("R11 last", cap[8], mk_hit(0,0,0,7));
    chk("R11 idle", 32'(busy), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule